// File: doc/BRIEF.md
# Transmit Pad and FCS Stage

This stage sits between a transmit frame buffer and the MAC serializer. Frame bytes arrive one per transfer. Each byte carries two flags, one for the first byte of a frame and one for the last. A frame may be assembled from any number of buffers of any size, including single-byte buffers. The stage sees only the joined byte stream, and idle gaps between bytes are allowed. Bytes pass straight through to the output. When the frame ends, the stage may append zero pad bytes, then a 4-byte CRC-32 frame check sequence, and then it marks the final byte.

Two configuration inputs set the policy.
- Padding has its own enable.
- The check sequence follows a global disable bit. A per-frame add flag, carried on the first byte of the frame, can override that disable.

Both settings and the add flag are captured on the first byte, so a change later in the frame does not affect that frame. The output is gated by the downstream ready. Valid is never raised while ready is low, and input is accepted only while bytes pass through.

Top module: `tpf_tx_pad_fcs`

## Requirements
- R1: Each accepted input byte leaves in the same transfer, unchanged and in order.
- R2: With padding enabled, a frame of fewer than 60 data bytes is extended with 0x00 bytes to exactly 60 bytes before any check sequence; frames of 60 or more bytes are not extended.
- R3: With padding disabled, no pad bytes are added.
- R4: With the global FCS disable at 0, a 4-byte check sequence follows every frame.
- R5: With the global FCS disable at 1, a check sequence follows only frames whose add flag is 1 on the byte with in_sof=1.
- R6: The add flag on any byte other than the first byte of a frame has no effect.
- R7: The check sequence is the IEEE 802.3 CRC-32 over data and pad bytes (polynomial 0x04C11DB7, seed all ones, result inverted, bit-reflected), sent least significant byte first.
- R8: out_last is 1 on the final output byte of each frame only.
- R9: out_valid is 0 whenever out_ready is 0; in_ready is 0 while pad or check bytes are emitted; under stalls and input gaps no byte is lost or repeated.
- R10: cfg_pad_en and cfg_fcs_off are taken from the first byte's cycle; later changes within the frame have no effect on it.
- R11: After reset no frame is in progress: out_valid is 0 while in_valid is 0, and in_ready equals out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pad_en | input | 1 | Enables padding of short frames |
| cfg_fcs_off | input | 1 | Global check-sequence disable |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte accepted this cycle when in_valid is also 1 |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_add_fcs | input | 1 | Per-frame add-check flag, read on the first byte only |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts a byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
Data bytes appear at the output in the same cycle in which they are accepted, because the pass-through path has no register. The first pad byte is due in the cycle after the final data byte is taken. The first check byte is due in the cycle after the last data or pad byte, and each later pad or check byte follows one accepted transfer later. The bench changes inputs at the falling edge and reads the outputs 8 ns later, just before the rising edge that completes the transfer, so every sample falls within the cycle in which that transfer is due. The frame and its appended bytes are then compared against a sequence built independently in the bench, which uses an MSB-first CRC form.

// File: rtl/tpf_pkg.sv
`timescale 1ns/1ps
package tpf_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } tpf_state_e;

  localparam int          FCS_BYTES    = 4;
  localparam int          FCS_IDX_W    = $clog2(FCS_BYTES);
  localparam logic [31:0] CRC_POLY_REF = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED     = 32'hFFFFFFFF;

  // Reflected CRC-32 advance by one byte, LSB of the byte first.
  function automatic logic [31:0] crc_advance(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REF) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/tpf_crc_acc.sv
`timescale 1ns/1ps
module tpf_crc_acc
  import tpf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic                 restart,
  input  logic [7:0]           din,
  input  logic [FCS_IDX_W-1:0] byte_sel,
  output logic [7:0]           fcs_byte
);

  logic [31:0] crc_r;
  logic [31:0] crc_base;
  logic [31:0] crc_nx;

  always_comb begin
    crc_base = restart ? CRC_SEED : crc_r;
    crc_nx   = crc_advance(crc_base, din);
    fcs_byte = ~crc_r[8*byte_sel +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_r <= CRC_SEED;
    end else if (upd_en) begin
      crc_r <= crc_nx;
    end
  end

endmodule

// File: rtl/tpf_len_track.sv
`timescale 1ns/1ps
module tpf_len_track #(
  parameter int MIN_DATA = 60,
  parameter int CNT_W    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic restart,
  output logic below_min
);

  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_DATA);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_r;
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_base  = restart ? '0 : cnt_r;
    cnt_inc   = (cnt_base == CNT_TOP) ? cnt_base : cnt_base + 1'b1;
    below_min = (cnt_inc < MIN_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0;
    end else if (step) begin
      cnt_r <= cnt_inc;
    end
  end

endmodule

// File: rtl/tpf_ctrl.sv
`timescale 1ns/1ps
module tpf_ctrl
  import tpf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic                 in_eof,
  input  logic                 in_add_fcs,
  input  logic                 cfg_pad_en,
  input  logic                 cfg_fcs_off,
  input  logic                 out_ready,
  input  logic                 below_min,
  output tpf_state_e           st,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic                 out_last,
  output logic                 step,
  output logic                 start_byte,
  output logic [FCS_IDX_W-1:0] fcs_idx
);

  localparam logic [FCS_IDX_W-1:0] IDX_LAST = FCS_IDX_W'(FCS_BYTES - 1);

  tpf_state_e           st_r, st_nx;
  logic                 pad_r, pad_nx, pad_eff;
  logic                 fcs_r, fcs_nx, fcs_eff;
  logic [FCS_IDX_W-1:0] idx_r, idx_nx;

  always_comb begin
    st_nx      = st_r;
    pad_nx     = pad_r;
    fcs_nx     = fcs_r;
    idx_nx     = idx_r;
    pad_eff    = pad_r;
    fcs_eff    = fcs_r;
    in_ready   = 1'b0;
    out_valid  = 1'b0;
    out_last   = 1'b0;
    step       = 1'b0;
    start_byte = 1'b0;
    case (st_r)
      ST_DATA: begin
        start_byte = in_sof;
        if (in_sof) begin
          pad_eff = cfg_pad_en;
          fcs_eff = !cfg_fcs_off || in_add_fcs;
        end
        in_ready  = out_ready;
        out_valid = in_valid && out_ready;
        step      = out_valid;
        out_last  = in_eof && !(pad_eff && below_min) && !fcs_eff;
        if (step) begin
          pad_nx = pad_eff;
          fcs_nx = fcs_eff;
          if (in_eof) begin
            idx_nx = '0;
            if (pad_eff && below_min) begin
              st_nx = ST_PAD;
            end else if (fcs_eff) begin
              st_nx = ST_FCS;
            end
          end
        end
      end
      ST_PAD: begin
        out_valid = out_ready;
        step      = out_ready;
        out_last  = !below_min && !fcs_r;
        if (step && !below_min) begin
          idx_nx = '0;
          st_nx  = fcs_r ? ST_FCS : ST_DATA;
        end
      end
      ST_FCS: begin
        out_valid = out_ready;
        out_last  = (idx_r == IDX_LAST);
        if (out_ready) begin
          if (idx_r == IDX_LAST) begin
            idx_nx = '0;
            st_nx  = ST_DATA;
          end else begin
            idx_nx = idx_r + 1'b1;
          end
        end
      end
      default: begin
        st_nx = ST_DATA;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r  <= ST_DATA;
      pad_r <= 1'b0;
      fcs_r <= 1'b0;
      idx_r <= '0;
    end else begin
      st_r  <= st_nx;
      pad_r <= pad_nx;
      fcs_r <= fcs_nx;
      idx_r <= idx_nx;
    end
  end

  assign st      = st_r;
  assign fcs_idx = idx_r;

endmodule

// File: rtl/tpf_tx_pad_fcs.sv
`timescale 1ns/1ps
module tpf_tx_pad_fcs
  import tpf_pkg::*;
#(
  parameter int MIN_DATA = 60,
  parameter int CNT_W    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_pad_en,
  input  logic       cfg_fcs_off,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       in_add_fcs,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);

  tpf_state_e           st;
  logic                 step;
  logic                 start_byte;
  logic                 below_min;
  logic [FCS_IDX_W-1:0] fcs_idx;
  logic [7:0]           crc_din;
  logic [7:0]           fcs_byte;

  tpf_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .in_add_fcs (in_add_fcs),
    .cfg_pad_en (cfg_pad_en),
    .cfg_fcs_off(cfg_fcs_off),
    .out_ready  (out_ready),
    .below_min  (below_min),
    .st         (st),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .step       (step),
    .start_byte (start_byte),
    .fcs_idx    (fcs_idx)
  );

  tpf_len_track #(
    .MIN_DATA(MIN_DATA),
    .CNT_W   (CNT_W)
  ) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .restart  (start_byte),
    .below_min(below_min)
  );

  tpf_crc_acc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (step),
    .restart (start_byte),
    .din     (crc_din),
    .byte_sel(fcs_idx),
    .fcs_byte(fcs_byte)
  );

  always_comb begin
    crc_din = (st == ST_DATA) ? in_data : 8'h00;
    case (st)
      ST_DATA: out_data = in_data;
      ST_FCS:  out_data = fcs_byte;
      default: out_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/tpf_tx_pad_fcs_chk.sv
`timescale 1ns/1ps
module tpf_tx_pad_fcs_chk #(
  parameter int MIN_DATA = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_pad_en,
  input logic       cfg_fcs_off,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_sof,
  input logic       in_eof,
  input logic       in_add_fcs,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);

  logic [15:0] ocnt;
  logic        pad_lat, fcs_lat;
  logic        fr_start, pad_now, fcs_now;

  always_comb begin
    fr_start = in_valid && in_ready && in_sof;
    pad_now  = fr_start ? cfg_pad_en : pad_lat;
    fcs_now  = fr_start ? (!cfg_fcs_off || in_add_fcs) : fcs_lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocnt    <= '0;
      pad_lat <= 1'b0;
      fcs_lat <= 1'b0;
    end else begin
      if (fr_start) begin
        pad_lat <= cfg_pad_en;
        fcs_lat <= !cfg_fcs_off || in_add_fcs;
      end
      if (out_valid) begin
        ocnt <= out_last ? 16'd0 : ((ocnt == 16'hFFFF) ? ocnt : ocnt + 16'd1);
      end
    end
  end

  p_valid_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !out_valid);

  p_no_intake_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready);

  p_pass_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (out_valid && out_data == in_data));

  p_min_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && pad_now) |-> (32'(ocnt) + 32'd1 >= 32'(MIN_DATA)));

  p_plain_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eof && !pad_now && !fcs_now) |-> out_last);

endmodule

bind tpf_tx_pad_fcs tpf_tx_pad_fcs_chk #(.MIN_DATA(MIN_DATA)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_pad_en (cfg_pad_en),
  .cfg_fcs_off(cfg_fcs_off),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .in_sof     (in_sof),
  .in_eof     (in_eof),
  .in_add_fcs (in_add_fcs),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last)
);

// File: tb/sim_tpf_tx_pad_fcs.sv
`timescale 1ns/1ps
module sim_tpf_tx_pad_fcs;

  localparam int MIN_DATA = 60;
  localparam int NV       = 9;
  // fields: len[18:11] pad[10] fcs_off[9] add[8] seed[7:0]
  localparam logic [18:0] VEC [NV] = '{
    {8'd10, 1'b1, 1'b0, 1'b0, 8'h11},
    {8'd10, 1'b0, 1'b0, 1'b0, 8'h22},
    {8'd70, 1'b1, 1'b0, 1'b0, 8'h33},
    {8'd10, 1'b1, 1'b1, 1'b0, 8'h44},
    {8'd10, 1'b1, 1'b1, 1'b1, 8'h55},
    {8'd59, 1'b1, 1'b1, 1'b1, 8'h66},
    {8'd60, 1'b1, 1'b0, 1'b0, 8'h77},
    {8'd1,  1'b0, 1'b1, 1'b0, 8'h88},
    {8'd1,  1'b1, 1'b0, 1'b0, 8'h99}
  };

  logic       clk, rst_n;
  logic       cfg_pad_en, cfg_fcs_off;
  logic       in_valid, in_sof, in_eof, in_add_fcs;
  logic [7:0] in_data;
  logic       out_ready;
  logic       in_ready, out_valid, out_last;
  logic [7:0] out_data;

  int         total, bad;
  logic [7:0] cap [0:255];
  logic [7:0] exp_b [0:255];
  int         cap_n, exp_n, last_pos, bp_viol, tick;
  logic       got_last, bp_mode, done;

  tpf_tx_pad_fcs u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pad_en(cfg_pad_en), .cfg_fcs_off(cfg_fcs_off),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .in_add_fcs(in_add_fcs), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // downstream ready pattern, changed at the falling edge
  always begin
    @(negedge clk);
    tick++;
    out_ready = bp_mode ? ((tick % 3) != 0) : 1'b1;
  end

  // output monitor, sampled 2 ns before the rising edge
  always begin
    @(negedge clk);
    #8;
    if (rst_n) begin
      if (out_valid && !out_ready) bp_viol++;
      if (out_valid && out_ready) begin
        if (cap_n < 256) cap[cap_n] = out_data;
        if (out_last && !got_last) begin
          last_pos = cap_n;
          got_last = 1'b1;
        end
        cap_n++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    logic [31:0] r;
    logic        fb;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        fb = c[31] ^ exp_b[i][k];
        c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    end
    c = ~c;
    for (int j = 0; j < 32; j++) r[j] = c[31-j];
    return r;
  endfunction

  task automatic build_exp(input int len, input bit pad, input bit off, input bit add,
                           input logic [7:0] seed);
    logic [31:0] f;
    exp_n = 0;
    for (int i = 0; i < len; i++) begin
      exp_b[exp_n] = 8'(seed + i * 7);
      exp_n++;
    end
    if (pad) begin
      while (exp_n < MIN_DATA) begin
        exp_b[exp_n] = 8'h00;
        exp_n++;
      end
    end
    if (!off || add) begin
      f = ref_crc(exp_n);
      for (int j = 0; j < 4; j++) begin
        exp_b[exp_n] = f[8*j +: 8];
        exp_n++;
      end
    end
  endtask

  task automatic send_frame(input int len, input bit pad, input bit off, input bit add,
                            input logic [7:0] seed, input bit gaps);
    cap_n = 0; got_last = 1'b0; last_pos = -1;
    cfg_pad_en = pad; cfg_fcs_off = off;
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 5) == 4) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      if (i == 1) begin
        // R10: flip the configuration after the first byte is taken
        cfg_pad_en = !pad; cfg_fcs_off = !off;
      end
      in_valid   = 1'b1;
      in_data    = 8'(seed + i * 7);
      in_sof     = (i == 0);
      in_eof     = (i == len - 1);
      in_add_fcs = (i == 0) ? add : !add;   // R6: opposite flag on later bytes
      #8;
      while (!in_ready) begin
        @(negedge clk);
        #8;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_add_fcs = 1'b0;
    wait (got_last == 1'b1);
    repeat (4) @(negedge clk);
    #9;
    cfg_pad_en = pad; cfg_fcs_off = off;
  endtask

  task automatic check_frame(input string req);
    int first_bad;
    first_bad = -1;
    check(cap_n == exp_n, {req, " length"}, cap_n, exp_n);
    for (int k = 0; k < exp_n && k < cap_n; k++) begin
      if (first_bad < 0 && cap[k] != exp_b[k]) first_bad = k;
    end
    check(first_bad < 0, {req, " byte content"},
          (first_bad < 0) ? 0 : int'(cap[first_bad]),
          (first_bad < 0) ? 0 : int'(exp_b[first_bad]));
    check(last_pos == exp_n - 1, "R8 last position", last_pos, exp_n - 1);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; cap_n = 0; exp_n = 0; last_pos = -1; bp_viol = 0; tick = 0;
    got_last = 1'b0; bp_mode = 1'b0; done = 1'b0; out_ready = 1'b1;
    rst_n = 1'b0; cfg_pad_en = 1'b0; cfg_fcs_off = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_add_fcs = 1'b0; in_data = 8'h00;

    repeat (3) @(negedge clk);
    #8;
    check(out_valid == 1'b0, "R11 valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R11 ready in reset", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #8;
    check(out_valid == 1'b0, "R11 valid after reset", int'(out_valid), 0);
    check(in_ready == out_ready, "R11 ready after reset", int'(in_ready), int'(out_ready));

    // table of frames: R1 R2 R3 R4 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      string tag;
      e = VEC[v];
      tag = $sformatf("vec%0d %s %s R1 R7 R10", v,
                      e[10] ? "R2" : "R3", e[9] ? "R5 R6" : "R4");
      build_exp(int'(e[18:11]), e[10], e[9], e[8], e[7:0]);
      send_frame(int'(e[18:11]), e[10], e[9], e[8], e[7:0], 1'b0);
      check_frame(tag);
    end

    // R9: downstream stalls and input gaps
    bp_mode = 1'b1;
    build_exp(10, 1'b1, 1'b0, 1'b0, 8'h0A);
    send_frame(10, 1'b1, 1'b0, 1'b0, 8'h0A, 1'b1);
    check_frame("R9 stalled padded");
    build_exp(70, 1'b1, 1'b1, 1'b1, 8'hC3);
    send_frame(70, 1'b1, 1'b1, 1'b1, 8'hC3, 1'b1);
    check_frame("R9 stalled long");
    build_exp(3, 1'b0, 1'b1, 1'b0, 8'h5A);
    send_frame(3, 1'b0, 1'b1, 1'b0, 8'h5A, 1'b1);
    check_frame("R9 stalled plain");
    bp_mode = 1'b0;
    repeat (2) @(negedge clk);
    check(bp_viol == 0, "R9 valid while not ready", bp_viol, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule